// File: doc/BRIEF.md
# ALU Operation Decoder

This block turns two pieces of instruction information into the 4-bit operation select of a 32-bit integer ALU. The first piece is a 2-bit operation class from the main instruction decoder. The second is the 6-bit function field of the current instruction. Memory-access and branch classes force a fixed operation and never look at the function field. The register-register class hands the choice to a second decoding level, which maps the function field onto add, subtract, AND, OR, set-less-than or NOR.

The block is purely combinational. An unused class code, or a register-register function code that is not recognised, gives a safe add select and raises an illegal flag. Later logic can use that flag to trap or squash the instruction.

Top module: `alu_op_decoder`

## Requirements
- R1: Class 00 (loads and stores) gives op_sel 0010 (add) and illegal 0 for every value of funct.
- R2: Class 01 (branch-on-equal) gives op_sel 0110 (subtract) and illegal 0 for every value of funct.
- R3: Class 10 with funct 100000 gives op_sel 0010 (add), and with funct 100010 gives op_sel 0110 (subtract), both with illegal 0.
- R4: Class 10 with funct 100100 gives op_sel 0000 (AND), and with funct 100101 gives op_sel 0001 (OR), both with illegal 0.
- R5: Class 10 with funct 101010 gives op_sel 0111 (set-less-than) with illegal 0.
- R6: Class 10 with funct 100111 gives op_sel 1100 (NOR) with illegal 0.
- R7: Class 10 with any funct other than the six listed in R3 to R6 gives op_sel 0010 and illegal 1.
- R8: Class 11 gives op_sel 0010 and illegal 1 for every value of funct.
- R9: The outputs depend only on the present inputs, hold no state, and are defined for all 256 input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the current instruction |
| op_sel | output | 4 | Operation select to the ALU |
| illegal | output | 1 | High for an unused class or an unknown function code |

## Verification
The assertions assume that both inputs carry defined values whenever they are evaluated. They also assume that the outputs are read only after the combinational path has settled on the present inputs. The bench meets both conditions. It changes op_class and funct only on the falling clock edge, always as fully specified values, and reads the outputs one nanosecond later. A table of chosen cases comes first. Then an exhaustive sweep covers all 256 class and function pairs, so every input the assertions see is a legal, settled combination.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;
  localparam int CLS_W = 2;
  localparam int FN_W  = 6;
  localparam int OP_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REGREG = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam logic [OP_W-1:0] OPS_AND = 4'b0000;
  localparam logic [OP_W-1:0] OPS_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OPS_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OPS_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OPS_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OPS_NOR = 4'b1100;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic            known;
    logic [OP_W-1:0] op;
  } fn_dec_t;

  // Function-field lookup; unknown codes fall back to add.
  function automatic fn_dec_t decode_fn(input logic [FN_W-1:0] f);
    fn_dec_t r;
    r.known = 1'b1;
    unique case (f)
      FN_ADD:  r.op = OPS_ADD;
      FN_SUB:  r.op = OPS_SUB;
      FN_AND:  r.op = OPS_AND;
      FN_OR:   r.op = OPS_OR;
      FN_NOR:  r.op = OPS_NOR;
      FN_SLT:  r.op = OPS_SLT;
      default: begin
        r.op    = OPS_ADD;
        r.known = 1'b0;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/alu_class_stage.sv
module alu_class_stage
  import alu_dec_pkg::*;
#(
  parameter int CW = CLS_W,
  parameter int OW = OP_W
) (
  input  logic [CW-1:0] cls,
  output logic          forced,
  output logic          defer,
  output logic          spare,
  output logic [OW-1:0] forced_op
);
  always_comb begin
    forced    = 1'b0;
    defer     = 1'b0;
    spare     = 1'b0;
    forced_op = OPS_ADD;
    unique case (op_class_e'(cls))
      CLS_MEM:    forced = 1'b1;
      CLS_BRANCH: begin
        forced    = 1'b1;
        forced_op = OPS_SUB;
      end
      CLS_REGREG: defer = 1'b1;
      default:    spare = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_funct_stage.sv
module alu_funct_stage
  import alu_dec_pkg::*;
#(
  parameter int FW = FN_W,
  parameter int OW = OP_W
) (
  input  logic [FW-1:0] fn,
  output logic          fn_known,
  output logic [OW-1:0] fn_op
);
  fn_dec_t dec;
  always_comb begin
    dec      = decode_fn(fn);
    fn_known = dec.known;
    fn_op    = dec.op;
  end
endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_dec_pkg::*;
(
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  funct,
  output logic [OP_W-1:0]  op_sel,
  output logic             illegal
);
  logic            cls_forced;
  logic            cls_defer;
  logic            cls_spare;
  logic [OP_W-1:0] cls_op;
  logic            fn_known;
  logic [OP_W-1:0] fn_op;

  alu_class_stage #(.CW(CLS_W), .OW(OP_W)) u_cls (
    .cls      (op_class),
    .forced   (cls_forced),
    .defer    (cls_defer),
    .spare    (cls_spare),
    .forced_op(cls_op)
  );

  alu_funct_stage #(.FW(FN_W), .OW(OP_W)) u_fn (
    .fn      (funct),
    .fn_known(fn_known),
    .fn_op   (fn_op)
  );

  always_comb begin
    op_sel  = OPS_ADD;
    illegal = 1'b0;
    if (cls_forced) begin
      op_sel = cls_op;
    end else if (cls_defer) begin
      op_sel  = fn_op;
      illegal = !fn_known;
    end else if (cls_spare) begin
      illegal = 1'b1;
    end
  end
endmodule

// File: rtl/alu_op_decoder_chk.sv
module alu_op_decoder_chk
  import alu_dec_pkg::*;
(
  input logic [CLS_W-1:0] op_class,
  input logic [FN_W-1:0]  funct,
  input logic [OP_W-1:0]  op_sel,
  input logic             illegal,
  input logic             cls_forced,
  input logic             cls_defer,
  input logic             cls_spare,
  input logic             fn_known
);
  always_comb begin
    if (op_class == 2'b00) AST_MEM_ADD: assert (op_sel == 4'b0010 && !illegal); // R1
    if (op_class == 2'b01) AST_BRANCH_SUB: assert (op_sel == 4'b0110 && !illegal); // R2
    if (op_class == 2'b10 && funct == 6'b100010) AST_RR_SUB: assert (op_sel == 4'b0110); // R3
    if (op_class == 2'b10 && funct == 6'b100101) AST_RR_OR: assert (op_sel == 4'b0001); // R4
    if (op_class == 2'b10 && funct == 6'b101010) AST_RR_SLT: assert (op_sel == 4'b0111); // R5
    if (op_class == 2'b10 && funct == 6'b100111) AST_RR_NOR: assert (op_sel == 4'b1100); // R6
    if (cls_defer && !fn_known) AST_RR_UNKNOWN: assert (illegal && op_sel == 4'b0010); // R7
    if (op_class == 2'b11) AST_SPARE_FLAG: assert (illegal && op_sel == 4'b0010); // R8
    AST_ONE_CLASS: assert ($onehot0({cls_forced, cls_defer, cls_spare}) &&
                           (cls_forced | cls_defer | cls_spare)); // R9
  end
endmodule

bind alu_op_decoder alu_op_decoder_chk u_chk (
  .op_class  (op_class),
  .funct     (funct),
  .op_sel    (op_sel),
  .illegal   (illegal),
  .cls_forced(cls_forced),
  .cls_defer (cls_defer),
  .cls_spare (cls_spare),
  .fn_known  (fn_known)
);

// File: tb/alu_op_decoder_bench.sv
`timescale 1ns/100ps
module alu_op_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [5:0] funct = 6'b000000;
  logic [3:0] op_sel;
  logic       illegal;
  int checks = 0;
  int errors = 0;
  int ticks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_op_decoder u_alu_op_decoder (
    .op_class(op_class), .funct(funct), .op_sel(op_sel), .illegal(illegal)
  );

  // {class, funct, op, illegal}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {2'b00, 6'b100010, 4'b0010, 1'b0},  // R1
    {2'b00, 6'b111111, 4'b0010, 1'b0},  // R1
    {2'b01, 6'b100000, 4'b0110, 1'b0},  // R2
    {2'b01, 6'b000000, 4'b0110, 1'b0},  // R2
    {2'b10, 6'b100000, 4'b0010, 1'b0},  // R3
    {2'b10, 6'b100010, 4'b0110, 1'b0},  // R3
    {2'b10, 6'b100100, 4'b0000, 1'b0},  // R4
    {2'b10, 6'b100101, 4'b0001, 1'b0},  // R4
    {2'b10, 6'b101010, 4'b0111, 1'b0},  // R5
    {2'b10, 6'b100111, 4'b1100, 1'b0},  // R6
    {2'b10, 6'b100110, 4'b0010, 1'b1},  // R7
    {2'b10, 6'b000000, 4'b0010, 1'b1},  // R7
    {2'b11, 6'b100000, 4'b0010, 1'b1},  // R8
    {2'b11, 6'b101010, 4'b0010, 1'b1}   // R8
  };

  function automatic logic [4:0] expect_of(input logic [1:0] c, input logic [5:0] f);
    logic [3:0] o = 4'd2;
    logic       bad = 1'b0;
    if (c == 2'd1) o = 4'd6;
    else if (c == 2'd3) bad = 1'b1;
    else if (c == 2'd2) begin
      if      (f == 6'd32) o = 4'd2;
      else if (f == 6'd34) o = 4'd6;
      else if (f == 6'd36) o = 4'd0;
      else if (f == 6'd37) o = 4'd1;
      else if (f == 6'd42) o = 4'd7;
      else if (f == 6'd39) o = 4'd12;
      else bad = 1'b1;
    end
    return {o, bad};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if ({op_sel, illegal} !== exp) begin
      errors++;
      $display("FAIL %s class=%b funct=%b got op=%b ill=%b exp op=%b ill=%b",
               req, op_class, funct, op_sel, illegal, exp[4:1], exp[0]);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [5:0] f);
    @(negedge clk);
    op_class = c;
    funct = f;
    #1;
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset-state", {4'b0010, 1'b0});
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][12:11], VEC[i][10:5]);
      check($sformatf("vec%0d R1-R8", i), VEC[i][4:0]);
    end
    // R9: exhaustive sweep, stateless: order of application must not matter
    for (int k = 0; k < 256; k++) begin
      apply(k[7:6], k[5:0]);
      check("R9 sweep", expect_of(k[7:6], k[5:0]));
    end
    for (int k = 255; k >= 0; k--) begin
      apply(k[7:6], k[5:0]);
      check("R9 reverse", expect_of(k[7:6], k[5:0]));
    end
    // R7 corner: neighbours of legal codes
    apply(2'b10, 6'b101011); check("R7 near-slt", {4'b0010, 1'b1});
    apply(2'b10, 6'b000010); check("R7 msb-clear", {4'b0010, 1'b1});
    // R1 after illegal: flag must drop
    apply(2'b00, 6'b110011); check("R1 flag-clear", {4'b0010, 1'b0});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule